// File: doc/BRIEF.md
# DMA Block Transfer Sequencer

This block is one DMA channel that moves memory in whole blocks. Configuration inputs give a 24-bit source start address, a 24-bit destination start address, a step mode for each side, the unit width (byte or 16-bit word), the number of units in a block, the number of blocks, and which side acts as the block area. A one-cycle `start` pulse captures the setup and arms the channel. From then on, each request strobe on `dreq` moves exactly one block. Each unit of the block is moved as a read from the source address followed by a write of the same data to the destination address.

The side chosen as the block area walks through its addresses during a block and returns to its start address when the block ends. The other side keeps advancing across blocks. A per-block unit counter reloads itself from the stored block size at the end of every block. A block counter counts completed blocks. When the last block finishes, the channel disarms and raises a sticky done interrupt.

Top module: `dma_blk_seq`

## Requirements
- R1: After reset, `mem_req`, `busy` and `done_irq` are all 0.
- R2: A `start` pulse captures the configuration and sets `busy` to 1. No memory access occurs until a request arrives.
- R3: Each unit is a read cycle (`mem_we`=0) at the source address, then a write cycle (`mem_we`=1) at the destination address that carries the data returned by the read. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R4: Step mode encoding per side: 0 = hold, 1 = increment, 2 = decrement, 3 = hold. The step is 1 for byte units (`cfg_word`=0) and 2 for word units (`cfg_word`=1). The address changes after every completed write. Arithmetic wraps modulo 2^24.
- R5: The block-area side returns to its start address after every block. The other side keeps advancing from block to block.
- R6: One request moves exactly `cfg_blk_size` units, where 0 means 256. The channel then waits for the next request.
- R7: Requests that arrive while a block is in progress are held as one pending request, however many arrive. Exactly one further block follows.
- R8: When the last of `cfg_blk_count` blocks completes, `busy` clears and `done_irq` sets. Later requests start no memory access.
- R9: `done_irq` stays at 1 until a `done_clr` pulse clears it.
- R10: `cfg_area_dst`=0 makes the source side the block area. `cfg_area_dst`=1 makes the destination side the block area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: capture configuration and arm channel |
| cfg_src_addr | input | 24 | Source start address |
| cfg_dst_addr | input | 24 | Destination start address |
| cfg_src_mode | input | 2 | Source step mode |
| cfg_dst_mode | input | 2 | Destination step mode |
| cfg_area_dst | input | 1 | Block area side select (1 = destination) |
| cfg_word | input | 1 | Unit width (1 = 16-bit word, 0 = byte) |
| cfg_blk_size | input | 8 | Units per block (0 = 256) |
| cfg_blk_count | input | 16 | Number of blocks |
| done_clr | input | 1 | Pulse: clear done interrupt |
| dreq | input | 1 | Transfer request strobe |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_word | output | 1 | Width of the current cycle |
| mem_addr | output | 24 | Memory cycle address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Memory cycle completion |
| busy | output | 1 | Channel armed |
| done_irq | output | 1 | Sticky transfer-complete interrupt |

## Verification
A fault in an address register shows on `mem_addr` at the next read or write cycle, within a unit or two. A block-area restore that goes wrong shows only at the first read or write of the next block. A bad unit counter shows at the end of a block: the block is too long or too short, and the following block's addresses shift. That is visible as soon as the expected access count is compared with the count actually observed. A bad block counter or pending flag shows only after the last block, as a missing or extra block, or as `busy` and `done_irq` at the wrong level. For that reason, each scenario also watches the ports for a quiet window after every block.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int SIZE_W  = 8;
    localparam int COUNT_W = 16;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_RSVD = 2'd3
    } step_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        step_mode_e src_mode;
        step_mode_e dst_mode;
        logic       area_dst;
        logic       word;
    } chan_cfg_t;

    function automatic logic [ADDR_W-1:0] next_addr(
        input logic [ADDR_W-1:0] cur,
        input step_mode_e        mode,
        input logic              word
    );
        logic [ADDR_W-1:0] stride;
        stride = word ? ADDR_W'(2) : ADDR_W'(1);
        case (mode)
            STEP_INC: next_addr = cur + stride;
            STEP_DEC: next_addr = cur - stride;
            default:  next_addr = cur;
        endcase
    endfunction
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_blk_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] start_val,
    input  step_mode_e    mode,
    input  logic          word,
    input  logic          advance,
    input  logic          restore,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            base_q <= start_val;
            addr_q <= start_val;
        end else if (advance) begin
            if (restore) addr_q <= base_q;
            else         addr_q <= AW'(next_addr(ADDR_W'(addr_q), mode, word));
        end
    end

    assign addr = addr_q;

    // R4
    hold_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && !restore && (mode == STEP_HOLD || mode == STEP_RSVD)) |=> $stable(addr));
endmodule

// File: rtl/dma_blk_counters.sv
module dma_blk_counters #(
    parameter int SW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] init_size,
    input  logic [CW-1:0] init_count,
    input  logic          unit_done,
    output logic          blk_end,
    output logic          xfer_end
);
    logic [SW-1:0] size_init_q;
    logic [SW-1:0] size_cnt_q;
    logic [CW-1:0] blk_cnt_q;

    assign blk_end  = unit_done && (size_cnt_q == SW'(1));
    assign xfer_end = blk_end && (blk_cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            size_init_q <= '0;
            size_cnt_q  <= '0;
            blk_cnt_q   <= '0;
        end else if (load) begin
            size_init_q <= init_size;
            size_cnt_q  <= init_size;
            blk_cnt_q   <= init_count;
        end else if (unit_done) begin
            if (blk_end) begin
                size_cnt_q <= size_init_q;
                blk_cnt_q  <= blk_cnt_q - CW'(1);
            end else begin
                size_cnt_q <= size_cnt_q - SW'(1);
            end
        end
    end

    // R6
    size_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_end && !load) |=> (size_cnt_q == size_init_q));
    // R8
    blk_cnt_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (!blk_end && !load) |=> $stable(blk_cnt_q));
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
    import dma_blk_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = SIZE_W,
    parameter int CW = COUNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_src_addr,
    input  logic [AW-1:0] cfg_dst_addr,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          cfg_area_dst,
    input  logic          cfg_word,
    input  logic [SW-1:0] cfg_blk_size,
    input  logic [CW-1:0] cfg_blk_count,
    input  logic          done_clr,
    input  logic          dreq,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done_irq
);
    localparam int NSIDE = 2;
    localparam int SRC   = 0;
    localparam int DST   = 1;

    seq_state_e    state_q;
    chan_cfg_t     cfg_q;
    logic          busy_q, done_q, pend_q;
    logic [DW-1:0] data_q;
    logic          unit_done, blk_end, xfer_end;

    logic [AW-1:0] side_start [NSIDE];
    step_mode_e    side_mode  [NSIDE];
    logic          side_area  [NSIDE];
    logic [AW-1:0] side_addr  [NSIDE];

    assign side_start[SRC] = cfg_src_addr;
    assign side_start[DST] = cfg_dst_addr;
    assign side_mode[SRC]  = cfg_q.src_mode;
    assign side_mode[DST]  = cfg_q.dst_mode;
    assign side_area[SRC]  = !cfg_q.area_dst;
    assign side_area[DST]  = cfg_q.area_dst;

    assign unit_done = (state_q == ST_WRITE) && mem_ack;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_unit #(.AW(AW)) u_addr (
            .clk      (clk),
            .rst      (rst),
            .load     (start),
            .start_val(side_start[g]),
            .mode     (side_mode[g]),
            .word     (cfg_q.word),
            .advance  (unit_done),
            .restore  (blk_end && side_area[g]),
            .addr     (side_addr[g])
        );
    end

    dma_blk_counters #(.SW(SW), .CW(CW)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .init_size (cfg_blk_size),
        .init_count(cfg_blk_count),
        .unit_done (unit_done),
        .blk_end   (blk_end),
        .xfer_end  (xfer_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            pend_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            if (done_clr) done_q <= 1'b0;
            if (start) begin
                cfg_q.src_mode <= step_mode_e'(cfg_src_mode);
                cfg_q.dst_mode <= step_mode_e'(cfg_dst_mode);
                cfg_q.area_dst <= cfg_area_dst;
                cfg_q.word     <= cfg_word;
                busy_q         <= 1'b1;
                pend_q         <= 1'b0;
                state_q        <= ST_IDLE;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (busy_q && pend_q) begin
                            state_q <= ST_READ;
                            pend_q  <= dreq;
                        end else if (busy_q && dreq) begin
                            pend_q <= 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (dreq) pend_q <= 1'b1;
                        if (mem_ack) begin
                            data_q  <= mem_rdata;
                            state_q <= ST_WRITE;
                        end
                    end
                    ST_WRITE: begin
                        if (dreq) pend_q <= 1'b1;
                        if (mem_ack) begin
                            if (xfer_end) begin
                                busy_q  <= 1'b0;
                                done_q  <= 1'b1;
                                pend_q  <= 1'b0;
                                state_q <= ST_IDLE;
                            end else if (blk_end) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_READ;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_word  = cfg_q.word;
    assign mem_addr  = (state_q == ST_WRITE) ? side_addr[DST] : side_addr[SRC];
    assign mem_wdata = data_q;
    assign busy      = busy_q;
    assign done_irq  = done_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !start) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R8
    done_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_irq) |-> !busy);
    // R7
    no_spurious_block_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !pend_q) |=> (state_q == ST_IDLE));
    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !done_clr) |=> done_irq);
endmodule

// File: tb/dma_blk_seq_bench.sv
module dma_blk_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [1:0]  cfg_src_mode = '0, cfg_dst_mode = '0;
    logic        cfg_area_dst = 1'b0, cfg_word = 1'b0;
    logic [7:0]  cfg_blk_size = '0;
    logic [15:0] cfg_blk_count = '0;
    logic        done_clr = 1'b0, dreq = 1'b0;
    logic        mem_req, mem_we, mem_word;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_ack = 1'b0;
    logic        busy, done_irq;

    int total = 0;
    int bad   = 0;
    int wait_cnt = 0;

    logic        lg_we   [$];
    logic [23:0] lg_addr [$];
    logic [15:0] lg_data [$];

    always #2 clk = ~clk;

    dma_blk_seq u_dma_blk_seq (
        .clk(clk), .rst(rst), .start(start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
        .cfg_area_dst(cfg_area_dst), .cfg_word(cfg_word),
        .cfg_blk_size(cfg_blk_size), .cfg_blk_count(cfg_blk_count),
        .done_clr(done_clr), .dreq(dreq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .done_irq(done_irq)
    );

    function automatic logic [15:0] rd_val(input logic [23:0] a);
        rd_val = {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + a[23:16]};
    endfunction

    function automatic logic [23:0] exp_addr(input logic [23:0] base, input logic [1:0] mode,
                                             input logic word, input int k);
        logic [23:0] off;
        off = 24'(k * (word ? 2 : 1));
        case (mode)
            2'd1:    exp_addr = base + off;
            2'd2:    exp_addr = base - off;
            default: exp_addr = base;
        endcase
    endfunction

    assign mem_rdata = rd_val(mem_addr);

    // memory model: ack after 0..2 wait cycles, log each completed cycle
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                mem_ack = 1'b1;
                lg_we.push_back(mem_we);
                lg_addr.push_back(mem_addr);
                lg_data.push_back(mem_wdata);
                wait_cnt = $urandom % 3;
            end else begin
                wait_cnt = wait_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_dreq();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask

    task automatic wait_log(input int n);
        int tmo = 0;
        while (lg_addr.size() < n && tmo < 20000) begin
            @(negedge clk);
            tmo++;
        end
    endtask

    task automatic run_case(input logic [23:0] sa, input logic [23:0] da,
                            input logic [1:0] sm, input logic [1:0] dm,
                            input logic area, input logic word,
                            input logic [7:0] size, input int count, input bit multi);
        int units;
        units = (size == 8'd0) ? 256 : int'(size);
        lg_we.delete(); lg_addr.delete(); lg_data.delete();
        @(negedge clk);
        cfg_src_addr = sa; cfg_dst_addr = da; cfg_src_mode = sm; cfg_dst_mode = dm;
        cfg_area_dst = area; cfg_word = word; cfg_blk_size = size;
        cfg_blk_count = 16'(count);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        repeat (10) @(negedge clk);
        chk(lg_addr.size() == 0, "R2", "accesses before request", lg_addr.size(), 0);
        for (int b = 0; b < count; b++) begin
            if (!(multi && b == 1)) pulse_dreq();
            if (multi && b == 0) begin
                repeat (2) @(negedge clk);
                pulse_dreq();
                pulse_dreq();
            end
            wait_log(2 * units * (b + 1));
            if (!(multi && b == 0)) begin
                repeat (20) @(negedge clk);
                chk(lg_addr.size() == 2 * units * (b + 1), multi ? "R7" : "R6",
                    "access count after block", lg_addr.size(), 2 * units * (b + 1));
            end
        end
        for (int b = 0; b < count; b++) begin
            for (int u = 0; u < units; u++) begin
                int ri, ks, kd;
                logic [23:0] es, ed;
                ri = 2 * (b * units + u);
                ks = area ? (b * units + u) : u;
                kd = area ? u : (b * units + u);
                es = exp_addr(sa, sm, word, ks);
                ed = exp_addr(da, dm, word, kd);
                if (ri + 1 < lg_addr.size()) begin
                    chk(lg_we[ri] == 1'b0 && lg_addr[ri] == es, area ? "R4" : "R5 R10",
                        "read address", lg_addr[ri], es);
                    chk(lg_we[ri+1] == 1'b1 && lg_addr[ri+1] == ed, area ? "R5 R10" : "R4",
                        "write address", lg_addr[ri+1], ed);
                    chk(lg_data[ri+1] == rd_val(lg_addr[ri]), "R3", "write data",
                        lg_data[ri+1], rd_val(lg_addr[ri]));
                end else begin
                    chk(1'b0, "R6", "missing access", lg_addr.size(), ri + 2);
                end
            end
        end
        chk(busy == 1'b0, "R8", "busy after last block", busy, 0);
        chk(done_irq == 1'b1, "R8", "done after last block", done_irq, 1);
        pulse_dreq();
        repeat (20) @(negedge clk);
        chk(lg_addr.size() == 2 * units * count, "R8", "access after done",
            lg_addr.size(), 2 * units * count);
        chk(done_irq == 1'b1, "R9", "done held", done_irq, 1);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        chk(done_irq == 1'b0, "R9", "done after clear", done_irq, 0);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(done_irq == 1'b0, "R1", "done after reset", done_irq, 0);
        // directed: reserved mode holds, source is block area, pending request
        run_case(24'h001000, 24'h002000, 2'd3, 2'd1, 1'b0, 1'b0, 8'd4, 3, 1'b1);
        // directed: word decrement, destination is block area
        run_case(24'h00A000, 24'h00B010, 2'd2, 2'd2, 1'b1, 1'b1, 8'd3, 3, 1'b0);
        // directed: increment wrap at top of address space
        run_case(24'hFFFFFD, 24'h000010, 2'd1, 2'd1, 1'b1, 1'b1, 8'd2, 2, 1'b0);
        // directed: block size 0 means 256 units
        run_case(24'h030000, 24'h040000, 2'd1, 2'd0, 1'b0, 1'b0, 8'd0, 1, 1'b0);
        for (int i = 0; i < 8; i++) begin
            run_case(24'($urandom), 24'($urandom), 2'($urandom), 2'($urandom),
                     1'($urandom), 1'($urandom), 8'(1 + $urandom % 6),
                     1 + int'($urandom % 4), 1'b0);
        end
        run_case(24'($urandom), 24'($urandom), 2'd1, 2'd2, 1'b1, 1'b0, 8'd5, 3, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule